// File: doc/BRIEF.md
# CAN receive message FIFO

This block is the receive store of a CAN controller. An acceptance stage hands it one accepted frame at a time: format, remote flag, length code, identifier and up to eight data bytes. A packing stage turns the frame into a variable-length record and appends the whole record in a single cycle to a 64-byte circular buffer. The record holds a header byte, then the identifier bytes, then the data bytes.

The host sees only the oldest record, through a read window. Window offset k returns the byte k places after the current record start. A release command drops that oldest record. The number of bytes to drop is decoded from the record's own header byte, so records of different lengths can share the buffer with no gaps. A frame that does not fit in the remaining space is dropped, and an overrun flag is raised. A separate command clears that flag.

Top module: `can_rx_msg_fifo`

## Requirements
- R1: The header byte of a record is laid out as follows: bit 7 is the extended-format flag, bit 6 is the remote-request flag, bits 5:4 are zero, and bits 3:0 hold the length code exactly as received, including values 9 to 15.
- R2: The identifier bytes follow the header.
  - Extended frame: four bytes, ID[28:21], ID[20:13], ID[12:5], then {ID[4:0], 3'b000}.
  - Base frame: two bytes, ID[10:3], then {ID[2:0], 5'b00000}.
  - The data bytes follow the identifier bytes, data byte 0 first, where data byte n is frm_data[8n+7:8n].
- R3: A record is 3 bytes long, plus 2 bytes for an extended frame, plus min(length code, 8) data bytes unless the frame is a remote request. byte_count grows by exactly this amount for each stored frame.
- R4: win_data equals the buffer byte at (record start + win_off) mod 64, combinationally.
- R5: A release while records are stored has three effects:
  - the record start advances by the head record length mod 64;
  - byte_count drops by that length;
  - msg_count drops by one.
  A release with msg_count = 0 changes nothing.
- R6: rx_ready is set when a record is stored. It is cleared when a release leaves msg_count at zero.
- R7: A frame whose record would take byte_count above 64 is not stored, and overrun is set. A record that brings byte_count to exactly 64 is stored.
- R8: The clear-overrun command clears overrun and leaves the stored records, the counts and the window unchanged. If a frame is dropped in the same cycle, overrun stays set.
- R9: A store and a release may happen in the same cycle, and both take effect. The space check for the store uses byte_count from before the release.
- R10: After reset, msg_count and byte_count are 0, and rx_ready and overrun are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe: an accepted frame is present |
| frm_ext | input | 1 | Frame uses the 29-bit identifier |
| frm_rtr | input | 1 | Frame is a remote request (carries no data) |
| frm_dlc | input | 4 | Length code of the frame |
| frm_id | input | 29 | Identifier, right-aligned (base frames use bits 10:0) |
| frm_data | input | 64 | Data bytes, byte n in bits 8n+7:8n |
| rel_cmd | input | 1 | Drop the oldest record |
| clr_ovr_cmd | input | 1 | Clear the overrun flag |
| win_off | input | 4 | Byte offset into the oldest record |
| win_data | output | 8 | Buffer byte at record start + win_off |
| msg_count | output | 7 | Number of stored records |
| byte_count | output | 7 | Number of occupied buffer bytes |
| rx_ready | output | 1 | At least one record is stored |
| overrun | output | 1 | A frame was dropped for lack of space |

## Verification
Most state faults in this block are visible through the window. A wrong start pointer, or a wrongly decoded head length, moves the window off the record boundary at the first release after the fault. From then on the header byte read at offset 0 is garbage. A miscounted byte total shows up in byte_count in the next cycle. It also appears later as a spurious or missing overrun when the buffer nears full.

Frames are swept over every combination of format, remote flag and length code while the pointers wrap. On top of that, an exact fill, drops against a full buffer, and same-cycle store-and-release are each exercised. After every cycle, each byte of the head record is compared against an arithmetic mirror.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;

  // Longest record: header + 4 identifier bytes + 8 data bytes
  localparam int REC_MAX = 13;
  localparam int LEN_W   = 4;

  typedef struct packed {
    logic        ext;
    logic        rtr;
    logic [3:0]  dlc;
    logic [28:0] id;
    logic [63:0] data;
  } can_frame_t;

  // Record length decoded from a header byte; length code capped at 8
  function automatic logic [LEN_W-1:0] hdr_rec_len(input logic [7:0] hdr);
    logic [LEN_W-1:0] dbytes;
    dbytes = (hdr[3:0] > 4'd8) ? 4'd8 : hdr[3:0];
    hdr_rec_len = 4'd3 + (hdr[7] ? 4'd2 : 4'd0) + (hdr[6] ? 4'd0 : dbytes);
  endfunction

endpackage

// File: rtl/can_rxq_packer.sv
module can_rxq_packer
  import can_rxq_pkg::*;
(
  input  can_frame_t                   frm,
  output logic [REC_MAX-1:0][7:0]      rec,
  output logic [LEN_W-1:0]             rec_len
);

  logic [7:0] hdr;
  int         dbase;

  always_comb begin
    hdr = {frm.ext, frm.rtr, 2'b00, frm.dlc};
    rec = '0;
    rec[0] = hdr;
    if (frm.ext) begin
      rec[1] = frm.id[28:21];
      rec[2] = frm.id[20:13];
      rec[3] = frm.id[12:5];
      rec[4] = {frm.id[4:0], 3'b000};
      dbase  = 5;
    end else begin
      rec[1] = frm.id[10:3];
      rec[2] = {frm.id[2:0], 5'b00000};
      dbase  = 3;
    end
    for (int b = 0; b < 8; b++) begin
      if (dbase + b < REC_MAX) begin
        rec[dbase + b] = frm.data[8*b +: 8];
      end
    end
    rec_len = hdr_rec_len(hdr);
  end

endmodule

// File: rtl/can_rxq_store.sv
module can_rxq_store
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OFF_W = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [PTR_W-1:0]          wr_ptr,
  input  logic [REC_MAX-1:0][7:0]   rec,
  input  logic [LEN_W-1:0]          rec_len,
  input  logic [PTR_W-1:0]          rd_base,
  input  logic [OFF_W-1:0]          rd_off,
  output logic [7:0]                rd_byte,
  output logic [7:0]                head_byte
);

  logic [7:0] ent [DEPTH];

  // Each entry decodes its distance from the write pointer and takes
  // the matching record byte when it lies inside the incoming record.
  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    logic [PTR_W-1:0] rel;
    logic             hit;
    logic [7:0]       q;

    assign rel = PTR_W'(j) - wr_ptr;
    assign hit = wr_en && (32'(rel) < 32'(rec_len));

    always_ff @(posedge clk) begin
      if (hit) begin
        q <= rec[rel[LEN_W-1:0]];
      end
    end

    assign ent[j] = q;
  end

  logic [PTR_W-1:0] rd_idx;
  assign rd_idx    = rd_base + PTR_W'(rd_off);
  assign rd_byte   = ent[rd_idx];
  assign head_byte = ent[rd_base];

endmodule

// File: rtl/can_rxq_ctrl.sv
module can_rxq_ctrl
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [LEN_W-1:0]   push_len,
  input  logic               rel_req,
  input  logic               clr_ovr,
  input  logic [7:0]         head_hdr,
  output logic               wr_en,
  output logic [PTR_W-1:0]   wr_ptr,
  output logic [PTR_W-1:0]   start_ptr,
  output logic [CNT_W-1:0]   byte_cnt,
  output logic [CNT_W-1:0]   msg_cnt,
  output logic               rx_ready,
  output logic               overrun
);

  logic [PTR_W-1:0] start_q, start_d, wr_q, wr_d;
  logic [CNT_W-1:0] byte_q, byte_d, msg_q, msg_d;
  logic             rdy_q, rdy_d, ovr_q, ovr_d;
  logic [CNT_W:0]   need;
  logic             fits, do_wr, drop, do_rel;
  logic [LEN_W-1:0] hlen;
  logic             start_en, wr_en_q, cnt_en, rdy_en, ovr_en;

  // Space check against the count from before any release this cycle
  always_comb begin
    need   = {1'b0, byte_q} + (CNT_W+1)'(push_len);
    fits   = need <= (CNT_W+1)'(DEPTH);
    do_wr  = push && fits;
    drop   = push && !fits;
    do_rel = rel_req && (msg_q != '0);
    hlen   = hdr_rec_len(head_hdr);
  end

  always_comb begin
    start_en = do_rel;
    wr_en_q  = do_wr;
    cnt_en   = do_wr || do_rel;
    rdy_en   = do_wr || do_rel;
    ovr_en   = drop || clr_ovr;

    start_d  = start_q + PTR_W'(hlen);
    wr_d     = wr_q + PTR_W'(push_len);
    byte_d   = byte_q + (do_wr ? CNT_W'(push_len) : '0) - (do_rel ? CNT_W'(hlen) : '0);
    msg_d    = msg_q + (do_wr ? CNT_W'(1) : '0) - (do_rel ? CNT_W'(1) : '0);

    if (do_wr)                          rdy_d = 1'b1;
    else if (do_rel && msg_q == CNT_W'(1)) rdy_d = 1'b0;
    else                                rdy_d = rdy_q;

    ovr_d = drop ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      wr_q    <= '0;
      byte_q  <= '0;
      msg_q   <= '0;
      rdy_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (start_en) start_q <= start_d;
      if (wr_en_q)  wr_q    <= wr_d;
      if (cnt_en) begin
        byte_q <= byte_d;
        msg_q  <= msg_d;
      end
      if (rdy_en)   rdy_q   <= rdy_d;
      if (ovr_en)   ovr_q   <= ovr_d;
    end
  end

  assign wr_en     = do_wr;
  assign wr_ptr    = wr_q;
  assign start_ptr = start_q;
  assign byte_cnt  = byte_q;
  assign msg_cnt   = msg_q;
  assign rx_ready  = rdy_q;
  assign overrun   = ovr_q;

  // R7
  bytes_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_q <= CNT_W'(DEPTH));

  // R6
  empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_q == '0) |-> (byte_q == '0) && !rdy_q);

  // R5
  empty_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && msg_q == '0 && !push) |=> $stable(start_q) && $stable(byte_q) && $stable(msg_q));

  // R5
  rel_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && msg_q != '0 && !push) |=>
      (byte_q == $past(byte_q) - CNT_W'($past(hlen))) && (msg_q == $past(msg_q) - CNT_W'(1)));

  // R7
  drop_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !fits && !rel_req) |=> overrun && $stable(msg_q) && $stable(byte_q));

  // R8
  clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr && !push && !rel_req) |=> !overrun && $stable(msg_q) && $stable(start_q));

endmodule

// File: rtl/can_rx_msg_fifo.sv
module can_rx_msg_fifo
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OFF_W = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic              frm_ext,
  input  logic              frm_rtr,
  input  logic [3:0]        frm_dlc,
  input  logic [28:0]       frm_id,
  input  logic [63:0]       frm_data,
  input  logic              rel_cmd,
  input  logic              clr_ovr_cmd,
  input  logic [OFF_W-1:0]  win_off,
  output logic [7:0]        win_data,
  output logic [CNT_W-1:0]  msg_count,
  output logic [CNT_W-1:0]  byte_count,
  output logic              rx_ready,
  output logic              overrun
);

  localparam int PTR_W = $clog2(DEPTH);

  can_frame_t               frm;
  logic [REC_MAX-1:0][7:0]  rec;
  logic [LEN_W-1:0]         rec_len;
  logic                     wr_en;
  logic [PTR_W-1:0]         wr_ptr, start_ptr;
  logic [7:0]               head_byte;

  assign frm = '{ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc, id: frm_id, data: frm_data};

  can_rxq_packer u_pack (
    .frm     (frm),
    .rec     (rec),
    .rec_len (rec_len)
  );

  can_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (frm_valid),
    .push_len  (rec_len),
    .rel_req   (rel_cmd),
    .clr_ovr   (clr_ovr_cmd),
    .head_hdr  (head_byte),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .start_ptr (start_ptr),
    .byte_cnt  (byte_count),
    .msg_cnt   (msg_count),
    .rx_ready  (rx_ready),
    .overrun   (overrun)
  );

  can_rxq_store #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u_store (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .rec       (rec),
    .rec_len   (rec_len),
    .rd_base   (start_ptr),
    .rd_off    (win_off),
    .rd_byte   (win_data),
    .head_byte (head_byte)
  );

endmodule

// File: tb/tb_can_rx_msg_fifo.sv
module tb_can_rx_msg_fifo;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        frm_valid, frm_ext, frm_rtr;
  logic [3:0]  frm_dlc;
  logic [28:0] frm_id;
  logic [63:0] frm_data;
  logic        rel_cmd, clr_ovr_cmd;
  logic [3:0]  win_off;
  logic [7:0]  win_data;
  logic [6:0]  msg_count, byte_count;
  logic        rx_ready, overrun;

  can_rx_msg_fifo dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ext(frm_ext),
    .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_id(frm_id), .frm_data(frm_data),
    .rel_cmd(rel_cmd), .clr_ovr_cmd(clr_ovr_cmd), .win_off(win_off),
    .win_data(win_data), .msg_count(msg_count), .byte_count(byte_count),
    .rx_ready(rx_ready), .overrun(overrun)
  );

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  logic [7:0] mm [DEPTH];
  logic [7:0] rb [13];
  int mstart, mwr, mcnt, mmsg;
  bit mrdy, movr;

  function automatic int len_of(bit ext, bit rtr, int dlc);
    int d;
    d = (dlc > 8) ? 8 : dlc;
    return 3 + (ext ? 2 : 0) + (rtr ? 0 : d);
  endfunction

  function automatic int hdr_len(logic [7:0] h);
    return len_of(h[7], h[6], int'(h[3:0]));
  endfunction

  // R1 R2: expected record bytes from the frame fields
  task automatic build(bit ext, bit rtr, logic [3:0] dlc, logic [28:0] id, logic [63:0] data);
    int base;
    rb[0] = {ext, rtr, 2'b00, dlc};
    if (ext) begin
      rb[1] = id[28:21]; rb[2] = id[20:13]; rb[3] = id[12:5]; rb[4] = {id[4:0], 3'b000};
      base = 5;
    end else begin
      rb[1] = id[10:3]; rb[2] = {id[2:0], 5'b00000};
      base = 3;
    end
    for (int b = 0; b < 8; b++) if (base + b < 13) rb[base + b] = data[8*b +: 8];
  endtask

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(bit push, bit ext, bit rtr, logic [3:0] dlc, logic [28:0] id,
                       logic [63:0] data, bit rel, bit clr);
    int pl, hl;
    bit fit, dorel, stored;
    @(negedge clk);
    frm_valid = push; frm_ext = ext; frm_rtr = rtr; frm_dlc = dlc;
    frm_id = id; frm_data = data; rel_cmd = rel; clr_ovr_cmd = clr;
    pl     = len_of(ext, rtr, int'(dlc));
    fit    = (mcnt + pl) <= DEPTH;          // R9: pre-release count
    stored = push && fit;
    dorel  = rel && (mmsg > 0);
    hl     = dorel ? hdr_len(mm[mstart]) : 0;
    if (stored) begin
      build(ext, rtr, dlc, id, data);
      for (int i = 0; i < pl; i++) mm[(mwr + i) % DEPTH] = rb[i];
      mwr = (mwr + pl) % DEPTH;
    end
    mcnt = mcnt + (stored ? pl : 0) - hl;
    if (dorel) mstart = (mstart + hl) % DEPTH;
    mmsg = mmsg + (stored ? 1 : 0) - (dorel ? 1 : 0);
    if (stored) mrdy = 1;
    else if (dorel && mmsg == 0) mrdy = 0;
    if (push && !fit) movr = 1;
    else if (clr) movr = 0;
    @(posedge clk);
    #1;
    frm_valid = 0; rel_cmd = 0; clr_ovr_cmd = 0;
  endtask

  task automatic check_all();
    chk("R3 R5 msg_count", int'(msg_count), mmsg);
    chk("R3 R5 byte_count", int'(byte_count), mcnt);
    chk("R6 rx_ready", int'(rx_ready), int'(mrdy));
    chk("R7 R8 overrun", int'(overrun), int'(movr));
    if (mmsg > 0) begin
      int hl;
      hl = hdr_len(mm[mstart]);
      for (int k = 0; k < hl; k++) begin
        @(negedge clk);
        win_off = 4'(k);
        #1;
        chk("R1 R2 R4 window", int'(win_data), int'(mm[(mstart + k) % DEPTH]));
      end
    end
  endtask

  task automatic push_f(bit ext, bit rtr, int dlc);
    apply(1, ext, rtr, 4'(dlc), 29'($urandom), {$urandom, $urandom}, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog R10: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    frm_valid = 0; frm_ext = 0; frm_rtr = 0; frm_dlc = 0; frm_id = 0; frm_data = 0;
    rel_cmd = 0; clr_ovr_cmd = 0; win_off = 0;
    mstart = 0; mwr = 0; mcnt = 0; mmsg = 0; mrdy = 0; movr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // R10 reset state
    chk("R10 msg_count", int'(msg_count), 0);
    chk("R10 byte_count", int'(byte_count), 0);
    chk("R10 rx_ready", int'(rx_ready), 0);
    chk("R10 overrun", int'(overrun), 0);

    // R1 R2 R3 R4 R5 R6: every format / remote / length code, pointers wrap
    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 16; d++) begin
          push_f(e[0], r[0], d);
          chk("R3 record length", int'(byte_count), len_of(e[0], r[0], d));
          check_all();
          apply(0, 0, 0, 0, 0, 0, 1, 0);
          check_all();
        end

    // R5: release with nothing stored
    apply(0, 0, 0, 0, 0, 0, 1, 0);
    check_all();

    // R7: fill to 52, drop, then exact fill to 64
    for (int i = 0; i < 4; i++) begin push_f(1, 0, 8); check_all(); end
    push_f(1, 0, 8);
    chk("R7 drop sets overrun", int'(overrun), 1);
    check_all();
    push_f(0, 1, 0);  check_all();
    push_f(0, 0, 6);
    chk("R7 exact fill", int'(byte_count), 64);
    check_all();
    push_f(0, 1, 0);  check_all();
    // R8: clear keeps records
    apply(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 clear overrun", int'(overrun), 0);
    check_all();
    // R8: drop and clear in the same cycle keeps overrun set
    apply(1, 0, 1, 0, 29'h5, 0, 0, 1);
    chk("R8 drop wins over clear", int'(overrun), 1);
    check_all();
    // R9: full buffer, release + 3-byte store same cycle -> store dropped
    apply(1, 0, 1, 0, 29'h7FF, 0, 1, 0);
    chk("R9 pre-release space check", int'(msg_count), 5);
    check_all();
    // R9: space available, both take effect
    apply(1, 1, 0, 2, 29'h1ABCDE57, 64'h1122, 1, 1);
    check_all();
    // drain
    for (int i = 0; i < 8; i++) begin apply(0, 0, 0, 0, 0, 0, 1, 0); check_all(); end

    // R9 and all: random mix
    for (int n = 0; n < 3000; n++) begin
      apply(($urandom % 2) == 0, $urandom % 2 == 0, $urandom % 4 == 0, 4'($urandom),
            29'($urandom), {$urandom, $urandom}, ($urandom % 3) == 0, ($urandom % 8) == 0);
      check_all();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule